// File: doc/BRIEF.md
# Self-Checking Multiplexer Logic Element

This block is one programmable logic element for a fine-grained array. At its core sits a two-input multiplexer. Each data leg of the multiplexer picks one of eight sources, and a control leg picks which incoming bus steers the selection. The result leaves the element either straight away or through a state flip-flop. A switch block forwards either that result or a neighbour's bus onto each of the four outgoing buses.

The element checks itself while it runs. The functional datapath is built twice. The two north results and the two flip-flop inputs are compared, and any difference sets a sticky fault flag. The state flip-flop is kept in three copies. The third copy only captures when the two functional copies agree. The reported state is always the two-out-of-three vote, so the state can be recovered after one copy is corrupted.

The configuration is a 20-bit word held outside the block. A global init loads the preset value into all three flip-flops and clears the flag. Two fault-injection inputs let a test corrupt the second datapath copy or the third flip-flop.

Top module: `mxc_cell`

## Requirements
- R1: After asynchronous reset, state_o and fault_o are 0.
- R2: The multiplexer result is the right leg when the control bit is 1 and the left leg when it is 0. The left leg is selected by cfg_i[19:17] and the right leg by cfg_i[16:14]. The source codes are: 0 constant 0, 1 north data, 2 east data, 3 south data, 4 west data, 5 constant 1, 6 the copy's own flip-flop, 7 north bus input.
- R3: When cfg_i[13] is 1, nout_o is the first flip-flop copy. When it is 0, nout_o is the multiplexer result of the first datapath copy.
- R4: The multiplexer control bit is bus_i[cfg_i[3:2]]. Bus index 0 is north, 1 east, 2 south and 3 west.
- R5: Each output bus d has a route field: north cfg_i[11:10], east cfg_i[9:8], south cfg_i[7:6], west cfg_i[5:4]. Route 0 drives nout_o. Route r>0 drives bus_i[(d+r) mod 4].
- R6: A clock edge with init_i high loads cfg_i[12] into all three flip-flops and clears fault_o.
- R7: On every edge without init, flip-flop copy k captures the multiplexer result of datapath copy k, for k = 1 and 2. state_o is the majority of the three copies. Setting inj_i[1] inverts only the value captured by the third copy, so it never changes state_o.
- R8: On an edge without init, fault_o becomes 1 if the two north results differed or the two flip-flop inputs differed. Once set, it stays 1 until init or reset.
- R9: When the two flip-flop inputs differ on an edge, the third copy keeps its value. inj_i[0] inverts the multiplexer result of the second datapath copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous global init: preset load, flag clear |
| cfg_i | input | 20 | Configuration word |
| din_i | input | 4 | Data inputs, index 0 north, 1 east, 2 south, 3 west |
| bus_i | input | 4 | Incoming buses, same index order |
| inj_i | input | 2 | Fault injection: bit 0 second datapath, bit 1 third flip-flop |
| nout_o | output | 1 | North output of the element |
| bus_o | output | 4 | Outgoing buses, same index order |
| state_o | output | 1 | Voted flip-flop state |
| fault_o | output | 1 | Sticky self-check fault flag |

## Verification
If the second datapath copy goes wrong, fault_o rises on the very next clock edge. This happens whether the error reaches the north output or only a flip-flop input. A wrong switch-block route shows up on bus_o in the same cycle. A corrupted single flip-flop copy must stay invisible on state_o. A corrupted pair instead changes state_o one edge after the bad capture. The third copy holds its value while the copies disagree, and the bench follows that through the cycles after the injection ends.

// File: rtl/mxc_pkg.sv
package mxc_pkg;
  localparam int CFG_W  = 20;
  localparam int NDIR   = 4;
  localparam int SRC_W  = 3;
  localparam int NSRC   = 1 << SRC_W;
  // field positions (routes are decoded by the switch block)
  localparam int LSEL_LO = 17;
  localparam int RSEL_LO = 14;
  localparam int REGEN_B = 13;
  localparam int PRESET_B = 12;
  localparam int ROUTE_HI = 11;  // north route at [11:10], then E, S, W
  localparam int CTRL_LO = 2;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction
endpackage

// File: rtl/mxc_src_sel.sv
module mxc_src_sel #(
  parameter int SEL_W = 3,
  localparam int N = 1 << SEL_W
) (
  input  logic [N-1:0]     srcs_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             y_o
);
  assign y_o = srcs_i[sel_i];
endmodule

// File: rtl/mxc_func.sv
module mxc_func
  import mxc_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [NDIR-1:0]  din_i,
  input  logic [NDIR-1:0]  bus_i,
  input  logic             fb_i,
  input  logic             flip_i,
  output logic             f_o,
  output logic             nout_o
);
  logic [NSRC-1:0] srcs;
  logic            left, right, ctrl;

  assign srcs = {bus_i[0], fb_i, 1'b1, din_i[3], din_i[2], din_i[1], din_i[0], 1'b0};
  assign ctrl = bus_i[cfg_i[CTRL_LO+1:CTRL_LO]];

  mxc_src_sel #(.SEL_W(SRC_W)) u_left (
    .srcs_i(srcs), .sel_i(cfg_i[LSEL_LO+SRC_W-1:LSEL_LO]), .y_o(left)
  );
  mxc_src_sel #(.SEL_W(SRC_W)) u_right (
    .srcs_i(srcs), .sel_i(cfg_i[RSEL_LO+SRC_W-1:RSEL_LO]), .y_o(right)
  );

  assign f_o    = (ctrl ? right : left) ^ flip_i;
  assign nout_o = cfg_i[REGEN_B] ? fb_i : f_o;
endmodule

// File: rtl/mxc_ff_triad.sv
module mxc_ff_triad
  import mxc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       preset_i,
  input  logic       d_a_i,
  input  logic       d_b_i,
  input  logic       flip3_i,
  output logic [2:0] q_o,
  output logic       vote_o
);
  logic agree;
  assign agree = (d_a_i == d_b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (init_i) begin
      q_o <= {3{preset_i}};
    end else begin
      q_o[0] <= d_a_i;
      q_o[1] <= d_b_i;
      if (agree) q_o[2] <= d_a_i ^ flip3_i;
    end
  end

  assign vote_o = maj3(q_o);
endmodule

// File: rtl/mxc_switch.sv
module mxc_switch
  import mxc_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             nout_i,
  input  logic [NDIR-1:0]  bus_i,
  output logic [NDIR-1:0]  bus_o
);
  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic [1:0] route, idx;
    assign route = cfg_i[ROUTE_HI-2*d -: 2];
    assign idx   = 2'(d) + route;
    assign bus_o[d] = (route == 2'd0) ? nout_i : bus_i[idx];
  end
endmodule

// File: rtl/mxc_cell.sv
module mxc_cell
  import mxc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [NDIR-1:0]  din_i,
  input  logic [NDIR-1:0]  bus_i,
  input  logic [1:0]       inj_i,
  output logic             nout_o,
  output logic [NDIR-1:0]  bus_o,
  output logic             state_o,
  output logic             fault_o
);
  logic [1:0] f, nout;
  logic [2:0] q;
  logic       fault_q, mismatch;

  for (genvar c = 0; c < 2; c++) begin : g_copy
    mxc_func u_func (
      .cfg_i(cfg_i), .din_i(din_i), .bus_i(bus_i),
      .fb_i(q[c]), .flip_i((c == 1) ? inj_i[0] : 1'b0),
      .f_o(f[c]), .nout_o(nout[c])
    );
  end

  mxc_ff_triad u_ff (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i),
    .preset_i(cfg_i[PRESET_B]), .d_a_i(f[0]), .d_b_i(f[1]),
    .flip3_i(inj_i[1]), .q_o(q), .vote_o(state_o)
  );

  mxc_switch u_sw (
    .cfg_i(cfg_i), .nout_i(nout[0]), .bus_i(bus_i), .bus_o(bus_o)
  );

  assign mismatch = (nout[0] != nout[1]) || (f[0] != f[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fault_q <= 1'b0;
    else if (init_i)   fault_q <= 1'b0;
    else if (mismatch) fault_q <= 1'b1;
  end

  assign nout_o  = nout[0];
  assign fault_o = fault_q;
endmodule

// File: rtl/mxc_cell_chk.sv
module mxc_cell_chk
  import mxc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             init_i,
  input logic [CFG_W-1:0] cfg_i,
  input logic [1:0]       f,
  input logic [1:0]       nout,
  input logic [2:0]       q,
  input logic             nout_o,
  input logic [NDIR-1:0]  bus_o,
  input logic             state_o,
  input logic             fault_o
);
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !init_i) |=> fault_o); // R8
  AST_FAULT_ON_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((f[0] != f[1] || nout[0] != nout[1]) && !init_i) |=> fault_o); // R8
  AST_INIT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !fault_o); // R6
  AST_INIT_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (q == {3{$past(cfg_i[PRESET_B])}})); // R6
  AST_Q3_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f[0] != f[1] && !init_i) |=> $stable(q[2])); // R9
  AST_VOTE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q[0] == q[1]) |-> (state_o == q[0])); // R7
  AST_NORTH_ROUTE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[ROUTE_HI -: 2] == 2'd0) |-> (bus_o[0] == nout_o)); // R5
endmodule

bind mxc_cell mxc_cell_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .cfg_i(cfg_i),
  .f(f), .nout(nout), .q(q), .nout_o(nout_o), .bus_o(bus_o),
  .state_o(state_o), .fault_o(fault_o)
);

// File: tb/tb_mxc_cell.sv
`timescale 1ns/1ps
module tb_mxc_cell;
  localparam int CLK_NS = 20;

  logic        clk_i = 0, rst_ni = 0, init_i = 0;
  logic [19:0] cfg_i = '0;
  logic [3:0]  din_i = '0, bus_i = '0;
  logic [1:0]  inj_i = '0;
  logic        nout_o, state_o, fault_o;
  logic [3:0]  bus_o;

  int vectors = 0, miscompares = 0;
  logic [2:0] mq = '0;
  logic       mfault = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  mxc_cell dut (.*);

  always #(CLK_NS/2) clk_i = ~clk_i;

  initial begin
    #(CLK_NS * 150000);
    miscompares++;
    $display("FAIL watchdog expired: actual hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  function automatic logic pick(input logic [2:0] s, input logic fb);
    case (s)
      3'd0: return 1'b0;
      3'd1: return din_i[0];
      3'd2: return din_i[1];
      3'd3: return din_i[2];
      3'd4: return din_i[3];
      3'd5: return 1'b1;
      3'd6: return fb;
      default: return bus_i[0];
    endcase
  endfunction

  function automatic logic mux_res(input logic fb);
    return bus_i[cfg_i[3:2]] ? pick(cfg_i[16:14], fb) : pick(cfg_i[19:17], fb);
  endfunction

  task automatic chk1(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // compare current outputs against the model, then advance the model over one edge
  task automatic step();
    logic fa, fb, na, nb, vote;
    logic [3:0] eb;
    #2;
    fa = mux_res(mq[0]);
    fb = mux_res(mq[1]) ^ inj_i[0];
    na = cfg_i[13] ? mq[0] : fa;
    nb = cfg_i[13] ? mq[1] : fb;
    vote = (mq[0] + mq[1] + mq[2]) >= 2;
    for (int d = 0; d < 4; d++) begin
      int r;
      r = cfg_i[11 - 2*d -: 2];
      eb[d] = (r == 0) ? na : bus_i[(d + r) % 4];
    end
    chk1("R2 R3 R4 nout", nout_o, na);
    chk1("R5 bus", bus_o[0], eb[0]);
    chk1("R5 bus east", bus_o[1], eb[1]);
    chk1("R5 bus south", bus_o[2], eb[2]);
    chk1("R5 bus west", bus_o[3], eb[3]);
    chk1("R7 state", state_o, vote);
    chk1("R8 fault", fault_o, mfault);
    @(posedge clk_i);
    if (init_i) begin
      mq = {3{cfg_i[12]}};
      mfault = 0;
    end else begin
      if (na != nb || fa != fb) mfault = 1;
      if (fa == fb) mq[2] = fa ^ inj_i[1];
      mq[0] = fa;
      mq[1] = fb;
    end
    @(negedge clk_i);
  endtask

  task automatic rnd_io();
    lfsr = lfsr * 32'd1664525 + 32'd1013904223;
    din_i = lfsr[27:24];
    bus_i = lfsr[31:28];
  endtask

  initial begin
    #3;
    chk1("R1 reset state", state_o, 1'b0);
    chk1("R1 reset fault", fault_o, 1'b0);
    #40 rst_ni = 1;
    @(negedge clk_i);

    // R6: init loads preset 1, then preset 0
    cfg_i = 20'h0_1000 | (20'd1 << 13);
    init_i = 1; step(); init_i = 0;
    chk1("R6 preset 1 loaded", state_o, 1'b1);
    chk1("R6 preset 1 on output", nout_o, 1'b1);
    cfg_i[12] = 0; init_i = 1; step(); init_i = 0;
    chk1("R6 preset 0 loaded", state_o, 1'b0);

    // mixed configurations, no injection
    for (int k = 0; k < 600; k++) begin
      if (k % 6 == 0) begin
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        cfg_i = lfsr[19:0];
      end
      rnd_io();
      step();
    end
    chk1("R8 no fault without injection", fault_o, 1'b0);

    // R7: third copy corruption hidden by the vote
    cfg_i = {3'd5, 3'd5, 1'b1, 1'b0, 8'h00, 4'h0};
    init_i = 1; step(); init_i = 0;
    inj_i = 2'b10;
    for (int k = 0; k < 4; k++) begin rnd_io(); step(); end
    inj_i = 0;
    chk1("R7 single upset hidden", state_o, 1'b1);
    chk1("R7 no flag on third copy upset", fault_o, 1'b0);

    // R9 and R8: second datapath flipped, third copy holds
    cfg_i = {3'd0, 3'd0, 1'b0, 1'b0, 8'h00, 4'h0};
    init_i = 1; step(); init_i = 0;
    inj_i = 2'b01; step(); inj_i = 0;
    chk1("R8 flag after datapath mismatch", fault_o, 1'b1);
    chk1("R9 third copy held, vote stays 0", state_o, 1'b0);
    for (int k = 0; k < 20; k++) begin rnd_io(); step(); end
    chk1("R8 flag sticky", fault_o, 1'b1);
    init_i = 1; step(); init_i = 0;
    chk1("R6 init clears flag", fault_o, 1'b0);

    // registered output mode with feedback and injection mixed in
    for (int k = 0; k < 300; k++) begin
      if (k % 10 == 0) begin
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        cfg_i = lfsr[19:0] | 20'h0_2000;
        inj_i = lfsr[21:20];
        init_i = lfsr[22];
      end else begin
        inj_i = 0; init_i = 0;
      end
      rnd_io();
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule